// File: doc/BRIEF.md
# Integer Execute Stage

This block is the integer execute step of a 32-bit load-store processor pipeline. It takes a fetched and already split instruction word together with the two source register values that the register file read for it. From fixed opcode and function-code values it works out which arithmetic, logical, compare or shift operation to run. It then produces the value to write back, the index of the register that receives it and a write strobe. The register file, memory, branch unit and multiplier sit outside and connect at these ports.

Shifts move the second source value (rt). The shift distance comes from the 5-bit shift field of the instruction for the fixed forms. For the variable forms it comes from the low five bits of the first source value (rs). Immediate forms take one operand from the low 16 bits of the instruction. Arithmetic and compare immediates sign-extend it, and logical immediates zero-extend it. A parameter chooses between a purely combinational path and a single output register.

Top module: `int_exec_stage`

## Requirements
- R1: Field positions are fixed: opcode bits [31:26], rs [25:21], rt [20:16], rd [15:11], shift field [10:6], function code [5:0], immediate [15:0]. Operations with opcode 000000 write register rd. All other operations write register rt.
- R2: With opcode 000000, function codes 100000/100001 give rs+rt and 100010/100011 give rs-rt. Both wrap modulo 2^32 with no exception, so 0x00641020 with rs=5, rt=7 writes 12 to register 2.
- R3: With opcode 000000, function codes 100100, 100101, 100110 and 100111 give the bitwise AND, OR, XOR and NOR of rs and rt.
- R4: Opcodes 001000 and 001001 add the sign-extended 16-bit immediate to rs, with wraparound.
- R5: The compares return 1 when the first operand is below the second and 0 otherwise. Function 101010 compares rs and rt signed, and function 101011 compares them unsigned. Opcode 001010 compares signed against the sign-extended immediate, and opcode 001011 compares unsigned against the sign-extended immediate.
- R6: Function codes 000000, 000010 and 000011 shift rt left, right with zero fill, and right with sign fill. The distance (0 to 31) comes from the shift field.
- R7: Function codes 000100, 000110 and 000111 shift rt left, right with zero fill, and right with sign fill. The distance is bits [4:0] of rs, and the upper bits of rs have no effect.
- R8: Opcodes 001100, 001101 and 001110 AND, OR and XOR rs with the zero-extended immediate.
- R9: Opcode 001111 places the immediate in result bits [31:16] and zeros in bits [15:0].
- R10: Any other opcode, and any other function code under opcode 000000, drives the write strobe, the result and the destination index to 0.
- R11: With OUT_REG=1, the outputs show the operation of the inputs from one clock earlier, and reset holds all outputs at 0. With OUT_REG=0, the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| instr | input | 32 | Instruction word |
| rs_val | input | XLEN | Value read from register rs |
| rt_val | input | XLEN | Value read from register rt |
| result | output | XLEN | Value to write back |
| dest_idx | output | 5 | Register index to write |
| wr_en | output | 1 | Write strobe |

## Verification
The bench builds the block twice, with XLEN=32 in both. One copy uses OUT_REG=1 and the other uses OUT_REG=0. Both copies receive the same stimulus, so the combinational path and the registered path, including its reset value and one-cycle lag, are compared against the same reference model. Directed vectors reach the sign-fill shift at full distance and the signed versus unsigned compare split. They also reach wraparound at 0x7fffffff and a variable-shift register whose upper bits are set. Random legal and illegal encodings then cover the remaining opcode and function-code mixes.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
    } alu_op_e;

    // primary opcodes
    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_ADDIU = 6'b001001;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_SLTIU = 6'b001011;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_XORI  = 6'b001110;
    localparam logic [5:0] OPC_LUI   = 6'b001111;

    // function codes under OPC_REG
    localparam logic [5:0] FN_SLL  = 6'b000000;
    localparam logic [5:0] FN_SRL  = 6'b000010;
    localparam logic [5:0] FN_SRA  = 6'b000011;
    localparam logic [5:0] FN_SLLV = 6'b000100;
    localparam logic [5:0] FN_SRLV = 6'b000110;
    localparam logic [5:0] FN_SRAV = 6'b000111;
    localparam logic [5:0] FN_ADD  = 6'b100000;
    localparam logic [5:0] FN_ADDU = 6'b100001;
    localparam logic [5:0] FN_SUB  = 6'b100010;
    localparam logic [5:0] FN_SUBU = 6'b100011;
    localparam logic [5:0] FN_AND  = 6'b100100;
    localparam logic [5:0] FN_OR   = 6'b100101;
    localparam logic [5:0] FN_XOR  = 6'b100110;
    localparam logic [5:0] FN_NOR  = 6'b100111;
    localparam logic [5:0] FN_SLT  = 6'b101010;
    localparam logic [5:0] FN_SLTU = 6'b101011;

    typedef struct packed {
        alu_op_e op;
        logic    b_is_imm;      // second operand from immediate
        logic    imm_signed;    // sign- vs zero-extension
        logic    amt_from_reg;  // shift distance from rs
        logic    dest_is_rt;    // write rt instead of rd
        logic    valid;         // legal encoding
    } dec_t;

endpackage

// File: rtl/iex_decode.sv
module iex_decode
    import int_exec_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output dec_t       dec
);

    always_comb begin
        dec = '{op: ALU_ADD, b_is_imm: 1'b0, imm_signed: 1'b0,
                amt_from_reg: 1'b0, dest_is_rt: 1'b0, valid: 1'b1};
        if (opcode == OPC_REG) begin
            unique case (funct)
                FN_ADD, FN_ADDU: dec.op = ALU_ADD;
                FN_SUB, FN_SUBU: dec.op = ALU_SUB;
                FN_AND:  dec.op = ALU_AND;
                FN_OR:   dec.op = ALU_OR;
                FN_XOR:  dec.op = ALU_XOR;
                FN_NOR:  dec.op = ALU_NOR;
                FN_SLT:  dec.op = ALU_SLT;
                FN_SLTU: dec.op = ALU_SLTU;
                FN_SLL:  dec.op = ALU_SLL;
                FN_SRL:  dec.op = ALU_SRL;
                FN_SRA:  dec.op = ALU_SRA;
                FN_SLLV: begin dec.op = ALU_SLL; dec.amt_from_reg = 1'b1; end
                FN_SRLV: begin dec.op = ALU_SRL; dec.amt_from_reg = 1'b1; end
                FN_SRAV: begin dec.op = ALU_SRA; dec.amt_from_reg = 1'b1; end
                default: dec.valid = 1'b0;
            endcase
        end else begin
            dec.b_is_imm   = 1'b1;
            dec.dest_is_rt = 1'b1;
            unique case (opcode)
                OPC_ADDI, OPC_ADDIU: begin dec.op = ALU_ADD;  dec.imm_signed = 1'b1; end
                OPC_SLTI:            begin dec.op = ALU_SLT;  dec.imm_signed = 1'b1; end
                OPC_SLTIU:           begin dec.op = ALU_SLTU; dec.imm_signed = 1'b1; end
                OPC_ANDI: dec.op = ALU_AND;
                OPC_ORI:  dec.op = ALU_OR;
                OPC_XORI: dec.op = ALU_XOR;
                OPC_LUI:  dec.op = ALU_LUI;
                default:  dec.valid = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/iex_shifter.sv
module iex_shifter #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] data,
    input  logic [SHW-1:0]  amt,
    input  logic            left,
    input  logic            arith,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] src;
    logic [XLEN-1:0] stg [0:SHW];
    logic            fill;

    // left shifts reuse the right-shift network on a bit-reversed word
    always_comb begin
        for (int k = 0; k < XLEN; k++) begin
            src[k] = left ? data[XLEN-1-k] : data[k];
        end
    end

    assign fill   = arith & ~left & data[XLEN-1];
    assign stg[0] = src;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int DIST = 1 << s;
        assign stg[s+1] = amt[s] ? {{DIST{fill}}, stg[s][XLEN-1:DIST]} : stg[s];
    end

    always_comb begin
        for (int k = 0; k < XLEN; k++) begin
            res[k] = left ? stg[SHW][XLEN-1-k] : stg[SHW][k];
        end
    end

endmodule

// File: rtl/iex_arith.sv
module iex_arith
    import int_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);

    logic            subtract;
    logic [XLEN:0]   sum;
    logic            lt_u;
    logic            lt_s;

    // one adder serves add, subtract and both compares
    assign subtract = (op != ALU_ADD);
    assign sum      = {1'b0, a} + {1'b0, subtract ? ~b : b} + {{XLEN{1'b0}}, subtract};
    assign lt_u     = ~sum[XLEN];
    assign lt_s     = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : sum[XLEN-1];

    always_comb begin
        unique case (op)
            ALU_ADD, ALU_SUB: res = sum[XLEN-1:0];
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_XOR:  res = a ^ b;
            ALU_NOR:  res = ~(a | b);
            ALU_SLT:  res = {{(XLEN-1){1'b0}}, lt_s};
            ALU_SLTU: res = {{(XLEN-1){1'b0}}, lt_u};
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
    import int_exec_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] result,
    output logic [4:0]      dest_idx,
    output logic            wr_en
);

    localparam int SHW   = $clog2(XLEN);
    localparam int IMM_W = 16;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic [4:0]      dest;
        logic            wen;
    } out_t;

    logic [5:0]       opc_f, fn_f;
    logic [4:0]       rt_f, rd_f, sh_f;
    logic [IMM_W-1:0] imm_f;
    dec_t             dec;
    logic [XLEN-1:0]  imm_ext, opnd_b, arith_res, shift_res;
    logic [SHW-1:0]   shift_amt;
    out_t             out_d;

    assign opc_f = instr[31:26];
    assign rt_f  = instr[20:16];
    assign rd_f  = instr[15:11];
    assign sh_f  = instr[10:6];
    assign fn_f  = instr[5:0];
    assign imm_f = instr[IMM_W-1:0];

    iex_decode u_decode (
        .opcode (opc_f),
        .funct  (fn_f),
        .dec    (dec)
    );

    assign imm_ext   = {{(XLEN-IMM_W){dec.imm_signed & imm_f[IMM_W-1]}}, imm_f};
    assign opnd_b    = dec.b_is_imm ? imm_ext : rt_val;
    assign shift_amt = dec.amt_from_reg ? rs_val[SHW-1:0] : SHW'(sh_f);

    iex_arith #(.XLEN(XLEN)) u_arith (
        .op  (dec.op),
        .a   (rs_val),
        .b   (opnd_b),
        .res (arith_res)
    );

    iex_shifter #(.XLEN(XLEN)) u_shifter (
        .data  (rt_val),
        .amt   (shift_amt),
        .left  (dec.op == ALU_SLL),
        .arith (dec.op == ALU_SRA),
        .res   (shift_res)
    );

    always_comb begin
        out_d = '0;
        if (dec.valid) begin
            out_d.wen  = 1'b1;
            out_d.dest = dec.dest_is_rt ? rt_f : rd_f;
            unique case (dec.op)
                ALU_SLL, ALU_SRL, ALU_SRA: out_d.result = shift_res;
                ALU_LUI: out_d.result = {imm_f, {(XLEN-IMM_W){1'b0}}};
                default: out_d.result = arith_res;
            endcase
        end
    end

    if (OUT_REG) begin : g_reg
        out_t out_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        assign result   = out_q.result;
        assign dest_idx = out_q.dest;
        assign wr_en    = out_q.wen;

        a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !dec.valid |=> (!wr_en && result == '0 && dest_idx == '0));
        a_r1_reg_dest_rd: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && opc_f == OPC_REG) |=> (wr_en && dest_idx == $past(instr[15:11])));
        a_r5_compare_bool: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && (dec.op == ALU_SLT || dec.op == ALU_SLTU)) |=> (result[XLEN-1:1] == '0));
        a_r6_sra_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && dec.op == ALU_SRA && rt_val[XLEN-1]) |=> result[XLEN-1]);
        a_r9_upper_imm: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && opc_f == OPC_LUI) |=>
                (result[IMM_W-1:0] == '0 && result[XLEN-1:XLEN-IMM_W] == $past(instr[IMM_W-1:0])));
    end else begin : g_comb
        assign result   = out_d.result;
        assign dest_idx = out_d.dest;
        assign wr_en    = out_d.wen;

        a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !dec.valid |-> (!wr_en && result == '0 && dest_idx == '0));
        a_r1_reg_dest_rd: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && opc_f == OPC_REG) |-> (wr_en && dest_idx == instr[15:11]));
        a_r5_compare_bool: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && (dec.op == ALU_SLT || dec.op == ALU_SLTU)) |-> (result[XLEN-1:1] == '0));
        a_r6_sra_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && dec.op == ALU_SRA && rt_val[XLEN-1]) |-> result[XLEN-1]);
        a_r9_upper_imm: assert property (@(posedge clk) disable iff (!rst_n)
            (dec.valid && opc_f == OPC_LUI) |->
                (result[IMM_W-1:0] == '0 && result[XLEN-1:XLEN-IMM_W] == instr[IMM_W-1:0]));
    end

endmodule

// File: tb/int_exec_stage_bench.sv
module int_exec_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] r_res, c_res;
    logic [4:0]  r_dst, c_dst;
    logic        r_wen, c_wen;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [37:0] pend;
    string       pend_tag;
    bit          have_pend = 1'b0;

    always #5 clk = ~clk;

    int_exec_stage #(.XLEN(32), .OUT_REG(1'b1)) u_int_exec_stage (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .result(r_res), .dest_idx(r_dst), .wr_en(r_wen)
    );

    int_exec_stage #(.XLEN(32), .OUT_REG(1'b0)) u_int_exec_stage_comb (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .result(c_res), .dest_idx(c_dst), .wr_en(c_wen)
    );

    // reference: {wen, dest, result}
    function automatic logic [37:0] model(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        logic [5:0]  opc = i[31:26];
        logic [5:0]  fn  = i[5:0];
        logic [4:0]  sh  = i[10:6];
        logic [31:0] se  = {{16{i[15]}}, i[15:0]};
        logic [31:0] ze  = {16'h0, i[15:0]};
        logic [31:0] r   = '0;
        logic        w   = 1'b1;
        logic [4:0]  d   = i[15:11];
        if (opc == 6'd0) begin
            case (fn)
                6'h20, 6'h21: r = a + b;
                6'h22, 6'h23: r = a - b;
                6'h24: r = a & b;
                6'h25: r = a | b;
                6'h26: r = a ^ b;
                6'h27: r = ~(a | b);
                6'h2a: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'h2b: r = (a < b) ? 32'd1 : 32'd0;
                6'h00: r = b << sh;
                6'h02: r = b >> sh;
                6'h03: r = $signed(b) >>> sh;
                6'h04: r = b << a[4:0];
                6'h06: r = b >> a[4:0];
                6'h07: r = $signed(b) >>> a[4:0];
                default: w = 1'b0;
            endcase
        end else begin
            d = i[20:16];
            case (opc)
                6'h08, 6'h09: r = a + se;
                6'h0a: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
                6'h0b: r = (a < se) ? 32'd1 : 32'd0;
                6'h0c: r = a & ze;
                6'h0d: r = a | ze;
                6'h0e: r = a ^ ze;
                6'h0f: r = {i[15:0], 16'h0};
                default: w = 1'b0;
            endcase
        end
        if (!w) begin
            r = '0;
            d = '0;
        end
        return {w, d, r};
    endfunction

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input int sh, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] opc, input int rs, input int rt, input logic [15:0] imm);
        return {opc, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(input string tag, input string path, input logic [37:0] got, input logic [37:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): got wen=%0b dst=%0d res=%08h, expected wen=%0b dst=%0d res=%08h",
                     tag, path, got[37], got[36:32], got[31:0], exp[37], exp[36:32], exp[31:0]);
        end
    endtask

    // one instruction per cycle; registered copy checked one cycle later (R11)
    task automatic step(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        if (have_pend) check({pend_tag, " R11"}, "registered", {r_wen, r_dst, r_res}, pend);
        instr  = i;
        rs_val = a;
        rt_val = b;
        #1;
        check(tag, "combinational", {c_wen, c_dst, c_res}, model(i, a, b));
        pend      = model(i, a, b);
        pend_tag  = tag;
        have_pend = 1'b1;
    endtask

    initial begin
        // R11: reset holds the registered outputs at zero
        instr  = 32'h00641020;
        rs_val = 32'd5;
        rt_val = 32'd7;
        @(negedge clk);
        @(negedge clk);
        check("R11 reset", "registered", {r_wen, r_dst, r_res}, 38'd0);
        rst_n = 1'b1;

        // R1 R2: example word and wraparound
        step(32'h00641020, 32'd5, 32'd7, "R1 R2 add example");
        step(rtype(1, 2, 9, 0, 6'h21), 32'h7fffffff, 32'd1, "R2 addu wrap");
        step(rtype(1, 2, 9, 0, 6'h20), 32'hffffffff, 32'd2, "R2 add wrap");
        step(rtype(4, 5, 6, 0, 6'h22), 32'd3, 32'd5, "R2 sub negative");
        step(rtype(4, 5, 7, 0, 6'h23), 32'h80000000, 32'd1, "R2 subu");
        // R3: logic
        step(rtype(1, 2, 3, 0, 6'h24), 32'hf0f0_1234, 32'hff00_ff00, "R3 and");
        step(rtype(1, 2, 3, 0, 6'h25), 32'hf0f0_1234, 32'h0f00_0001, "R3 or");
        step(rtype(1, 2, 3, 0, 6'h26), 32'haaaa_5555, 32'hffff_0000, "R3 xor");
        step(rtype(1, 2, 3, 0, 6'h27), 32'h0000_00ff, 32'h0f00_0000, "R3 nor");
        // R4: sign-extended immediate, dest = rt
        step(itype(6'h08, 8, 16, 16'hfffc), 32'd10, 32'h0, "R1 R4 addi negative");
        step(itype(6'h09, 8, 17, 16'h7fff), 32'h7fff_ffff, 32'h0, "R4 addiu wrap");
        // R5: compares
        step(rtype(1, 2, 3, 0, 6'h2a), 32'hffffffff, 32'd1, "R5 slt signed");
        step(rtype(1, 2, 3, 0, 6'h2b), 32'hffffffff, 32'd1, "R5 sltu unsigned");
        step(rtype(1, 2, 3, 0, 6'h2a), 32'd4, 32'd4, "R5 slt equal");
        step(itype(6'h0a, 1, 2, 16'h8000), 32'hffff0000, 32'h0, "R5 slti");
        step(itype(6'h0b, 1, 2, 16'hffff), 32'd5, 32'h0, "R5 sltiu extended");
        // R6: fixed shifts
        step(rtype(0, 3, 4, 2, 6'h00), 32'h0, 32'h29, "R6 sll");
        step(rtype(0, 3, 4, 2, 6'h02), 32'h0, 32'h8000_0029, "R6 srl");
        step(rtype(0, 3, 4, 2, 6'h03), 32'h0, 32'hffff_fff5, "R6 sra sign fill");
        step(rtype(0, 3, 4, 31, 6'h03), 32'h0, 32'h8000_0000, "R6 sra 31");
        step(rtype(0, 3, 4, 0, 6'h00), 32'h0, 32'h1234_5678, "R6 sll 0");
        // R7: variable shifts, upper rs bits ignored
        step(rtype(2, 3, 4, 0, 6'h04), 32'h0000_0021, 32'h8000_0003, "R7 sllv upper ignored");
        step(rtype(2, 3, 4, 0, 6'h06), 32'hffff_ffe4, 32'hf000_0000, "R7 srlv");
        step(rtype(2, 3, 4, 0, 6'h07), 32'hffff_ffe4, 32'hf000_0000, "R7 srav");
        step(rtype(2, 3, 4, 9, 6'h07), 32'h0000_0000, 32'h8000_0000, "R7 srav shamt ignored");
        // R8: zero-extended logical immediates
        step(itype(6'h0c, 1, 5, 16'hffff), 32'hffff_ffff, 32'h0, "R8 andi");
        step(itype(6'h0d, 1, 5, 16'h8001), 32'h1000_0000, 32'h0, "R8 ori");
        step(itype(6'h0e, 1, 5, 16'hffff), 32'hffff_ffff, 32'h0, "R8 xori");
        // R9
        step(itype(6'h0f, 7, 6, 16'h1234), 32'hdead_beef, 32'h0, "R9 lui");
        // R10: illegal encodings
        step({6'b000010, 26'h40}, 32'd1, 32'd2, "R10 bad opcode");
        step(rtype(1, 2, 3, 0, 6'h01), 32'd1, 32'd2, "R10 bad funct 000001");
        step(rtype(1, 2, 3, 0, 6'h28), 32'd1, 32'd2, "R10 bad funct 101000");
        step(32'h00641020, 32'd8, 32'd9, "R10 legal after illegal");

        // random mix of legal and illegal encodings
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            w = $urandom;
            case ($urandom_range(0, 3))
                0: w[31:26] = 6'd0;
                1: w[31:26] = 6'(8 + $urandom_range(0, 7));
                2: begin w[31:26] = 6'd0; w[5:0] = 6'(32 + $urandom_range(0, 11)); end
                default: ;
            endcase
            step(w, $urandom, $urandom, "R2 R3 R4 R5 R6 R7 R8 R9 R10 mix");
        end

        @(negedge clk);
        check({pend_tag, " R11"}, "registered", {r_wen, r_dst, r_res}, pend);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule